// File: doc/BRIEF.md
# Fetch Group Assembler

This block turns one instruction cache line into a group of instruction slots for the decode stage, all in one cycle. It takes the PC triple of the current thread: the PC, the next PC, and the micro-op index inside a macro-op. It starts at the word that the PC selects in the line and walks forward. For each word it computes the next triple and fills one slot. The group ends at the first of four conditions:

- the line runs out;
- the slot budget for the cycle is used up;
- a redirect is predicted;
- a quiesce instruction is reached.

Decode, branch prediction and the cache are outside the block. The surrounding pipeline presents their results as per-word attribute inputs: the micro-op count, whether the word is a control-flow instruction, whether it is predicted taken, the predicted target, and whether it is a quiesce instruction.

The group is registered, so the slots appear one clock after the `go` strobe. In the same cycle the block presents the PC triple the thread should continue from, with a write enable. If translation of the line failed, the group is a single synthetic no-op slot that carries the fault toward commit, and the thread's PC triple is left alone. A parameter selects between two next-PC rules: the immediate-redirect rule (the default) and a delayed-branch rule in which the instruction after a branch always executes. Every emitted slot is stamped from a global running sequence number.

Top module: `fetch_group_asm`

## Requirements
- R1: Walking starts at the line word indexed by PC bits [log2(LINE_BYTES)-1:2], with the low two PC bits ignored. Slot k carries the PC, the micro-op index and the 32-bit word (word i is `line_data[i]`) that it was built from.
- R2: The group never goes past the last word of the line. A start near the end of the line yields fewer slots than the width allows.
- R3: At most W slots are emitted per group, and `out_cnt` equals the number of set bits in `slot_vld`, which form a prefix starting at bit 0.
- R4: A plain word (not control, one micro-op) yields a next triple of (next PC, next PC + 4, 0). This is the slot's predicted target (`slot_tgt_pc`, `slot_tgt_npc`), and the walk continues with the following word.
- R5: A word with micro-op count N > 1 fills consecutive slots with micro-op indices rising by one from the incoming index. The walk moves to the next word only after index N-1. When the width cuts a macro-op short, the written-back triple keeps the same PC with the following micro-op index.
- R6: If, when a word is first reached, PC + 4 differs from the next PC, the slots of that word are still emitted, and then the group ends.
- R7: A control word predicted taken ends the group after its slot, with next triple (target, target + 4, 0). A control word not taken gives (PC + 4, PC + 8, 0) and the walk continues.
- R8: A quiesce word is emitted and counted, the group ends after it, and `out_state` is 1 (quiesce pending). Otherwise `out_state` is 0 (running), unless R9 applies.
- R9: With `fault` set, the group is exactly one slot with the incoming PC and micro-op index, word NOP_INSN, predicted target (next PC, next PC + 4), `out_fault` set and `out_state` 2 (trap pending). `wb_we` stays low.
- R10: Without a fault, `wb_we` is raised and `wb_pc`/`wb_npc`/`wb_upc` hold the triple that follows the last emitted slot.
- R11: Slot sequence numbers start at 0 after reset and count up by one per emitted slot across groups, fault slots included.
- R12: Results appear exactly one clock after a cycle with `go` high. In every other cycle `out_vld`, `slot_vld` and `wb_we` are low.
- R13: After reset, `out_vld`, `slot_vld` and `wb_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| go | input | 1 | Assemble a group from the present inputs |
| tid | input | TIDW | Thread owning the request |
| pc | input | AW | Current PC |
| npc | input | AW | Current next PC |
| upc | input | UW | Current micro-op index |
| fault | input | 1 | Translation of the line failed |
| line_data | input | WORDS x 32 | Cache line, word i at index i |
| w_uops | input | WORDS x UW | Micro-op count per word (0 or 1 means a single op) |
| w_ctrl | input | WORDS | Word is a control-flow instruction |
| w_taken | input | WORDS | Control word predicted taken |
| w_target | input | WORDS x AW | Predicted target per word |
| w_quiesce | input | WORDS | Word is a quiesce instruction |
| out_vld | output | 1 | Group present this cycle |
| out_tid | output | TIDW | Thread of the group |
| out_cnt | output | CW | Number of slots |
| slot_vld | output | W | Per-slot valid |
| slot_pc | output | W x AW | Slot PC |
| slot_upc | output | W x UW | Slot micro-op index |
| slot_insn | output | W x 32 | Slot instruction word |
| slot_tgt_pc | output | W x AW | Slot predicted next PC |
| slot_tgt_npc | output | W x AW | Slot predicted next-next PC |
| slot_seq | output | W x SEQW | Slot sequence number |
| out_fault | output | 1 | Slot 0 carries a fault |
| out_state | output | 2 | Thread state after the group: 0 running, 1 quiesce, 2 trap |
| wb_we | output | 1 | Write back PC triple |
| wb_tid | output | TIDW | Thread to write back |
| wb_pc | output | AW | New PC |
| wb_npc | output | AW | New next PC |
| wb_upc | output | UW | New micro-op index |

## Verification
The properties rely on the attribute inputs describing a decoded line consistently. A control-flow word has a single micro-op. Any incoming micro-op index is below the count of the word it points at. Inputs are held stable for the whole cycle in which `go` is high. The stimulus sets every attribute from a cleared default per scenario and raises `go` for one cycle at a time, separated by idle cycles. Start PCs are word-aligned and inside the presented line, and micro-op resumption starts from index 0. These choices keep the bench inside those limits.

// File: rtl/fga_pkg.sv
package fga_pkg;
   localparam int FGA_ISZ = 4;

   typedef enum logic [1:0] {
      FGA_RUN     = 2'd0,
      FGA_QUIESCE = 2'd1,
      FGA_TRAP    = 2'd2
   } fga_thr_e;
endpackage

// File: rtl/fga_nextpc.sv
module fga_nextpc #(
   parameter int AW         = 32,
   parameter int UW         = 4,
   parameter bit DELAY_SLOT = 1'b0
) (
   input  logic [AW-1:0] cur_pc,
   input  logic [AW-1:0] cur_npc,
   input  logic [UW-1:0] cur_upc,
   input  logic          is_ctrl,
   input  logic          is_taken,
   input  logic          stay_macro,
   input  logic [AW-1:0] tgt,
   output logic [AW-1:0] nx_pc,
   output logic [AW-1:0] nx_npc,
   output logic [UW-1:0] nx_upc
);
   localparam logic [AW-1:0] ISZ = AW'(fga_pkg::FGA_ISZ);

   logic [AW-1:0] br_pc, br_npc;

   generate
      if (DELAY_SLOT) begin : g_delayed
         always_comb begin
            br_pc  = cur_npc;
            br_npc = is_taken ? tgt : cur_npc + ISZ;
         end
      end else begin : g_direct
         always_comb begin
            br_pc  = is_taken ? tgt : cur_pc + ISZ;
            br_npc = br_pc + ISZ;
         end
      end
   endgenerate

   always_comb begin
      if (is_ctrl) begin
         nx_pc  = br_pc;
         nx_npc = br_npc;
         nx_upc = '0;
      end else if (stay_macro) begin
         nx_pc  = cur_pc;
         nx_npc = cur_npc;
         nx_upc = cur_upc + UW'(1);
      end else begin
         nx_pc  = cur_npc;
         nx_npc = cur_npc + ISZ;
         nx_upc = '0;
      end
   end
endmodule

// File: rtl/fga_slot_stage.sv
module fga_slot_stage #(
   parameter int AW          = 32,
   parameter int UW          = 4,
   parameter int LINE_BYTES  = 32,
   parameter bit DELAY_SLOT  = 1'b0,
   localparam int WORDS      = LINE_BYTES / 4,
   localparam int WIW        = $clog2(WORDS),
   localparam int OFFW       = $clog2(LINE_BYTES) + 1
) (
   input  logic                        i_act,
   input  logic [OFFW-1:0]             i_off,
   input  logic [AW-1:0]               i_pc,
   input  logic [AW-1:0]               i_npc,
   input  logic [UW-1:0]               i_upc,
   input  logic                        i_mid,
   input  logic                        i_brk,
   input  logic [WORDS-1:0][31:0]      line_data,
   input  logic [WORDS-1:0][UW-1:0]    w_uops,
   input  logic [WORDS-1:0]            w_ctrl,
   input  logic [WORDS-1:0]            w_taken,
   input  logic [WORDS-1:0][AW-1:0]    w_target,
   input  logic [WORDS-1:0]            w_quiesce,
   output logic                        s_emit,
   output logic [31:0]                 s_insn,
   output logic [AW-1:0]               s_tgt_pc,
   output logic [AW-1:0]               s_tgt_npc,
   output logic                        s_qui,
   output logic                        o_act,
   output logic [OFFW-1:0]             o_off,
   output logic [AW-1:0]               o_pc,
   output logic [AW-1:0]               o_npc,
   output logic [UW-1:0]               o_upc,
   output logic                        o_mid,
   output logic                        o_brk
);
   localparam logic [AW-1:0] ISZ = AW'(fga_pkg::FGA_ISZ);

   logic [WIW-1:0] widx;
   logic [UW-1:0]  nu;
   logic           multi, last_uop, ctrl, taken, cont, brk, ends;
   logic [AW-1:0]  n_pc, n_npc;
   logic [UW-1:0]  n_upc;

   always_comb begin
      widx     = i_off[OFFW-2:2];
      nu       = w_uops[widx];
      multi    = nu > UW'(1);
      last_uop = (i_upc == nu - UW'(1));
      ctrl     = w_ctrl[widx];
      taken    = ctrl && w_taken[widx];
      cont     = multi && !last_uop && !ctrl;
      // redirect test is made once, when a word is first reached
      brk      = i_mid ? i_brk : ((i_pc + ISZ) != i_npc);
      ends     = !cont && (brk || taken);
   end

   fga_nextpc #(.AW(AW), .UW(UW), .DELAY_SLOT(DELAY_SLOT)) npc_i (
      .cur_pc     (i_pc),
      .cur_npc    (i_npc),
      .cur_upc    (i_upc),
      .is_ctrl    (ctrl),
      .is_taken   (taken),
      .stay_macro (cont),
      .tgt        (w_target[widx]),
      .nx_pc      (n_pc),
      .nx_npc     (n_npc),
      .nx_upc     (n_upc)
   );

   always_comb begin
      s_emit    = i_act && (i_off < OFFW'(LINE_BYTES));
      s_insn    = line_data[widx];
      s_tgt_pc  = n_pc;
      s_tgt_npc = n_npc;
      s_qui     = s_emit && w_quiesce[widx];
      o_act     = s_emit && !w_quiesce[widx] && !ends;
      o_off     = (s_emit && !cont) ? i_off + OFFW'(4) : i_off;
      o_pc      = s_emit ? n_pc  : i_pc;
      o_npc     = s_emit ? n_npc : i_npc;
      o_upc     = s_emit ? n_upc : i_upc;
      o_mid     = s_emit && cont;
      o_brk     = brk;
   end
endmodule

// File: rtl/fetch_group_asm.sv
module fetch_group_asm #(
   parameter int          W          = 4,
   parameter int          AW         = 32,
   parameter int          UW         = 4,
   parameter int          LINE_BYTES = 32,
   parameter int          TIDW       = 2,
   parameter int          SEQW       = 16,
   parameter bit          DELAY_SLOT = 1'b0,
   parameter logic [31:0] NOP_INSN   = 32'hFFFF_0001,
   localparam int         WORDS      = LINE_BYTES / 4,
   localparam int         CW         = $clog2(W + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        go,
   input  logic [TIDW-1:0]             tid,
   input  logic [AW-1:0]               pc,
   input  logic [AW-1:0]               npc,
   input  logic [UW-1:0]               upc,
   input  logic                        fault,
   input  logic [WORDS-1:0][31:0]      line_data,
   input  logic [WORDS-1:0][UW-1:0]    w_uops,
   input  logic [WORDS-1:0]            w_ctrl,
   input  logic [WORDS-1:0]            w_taken,
   input  logic [WORDS-1:0][AW-1:0]    w_target,
   input  logic [WORDS-1:0]            w_quiesce,
   output logic                        out_vld,
   output logic [TIDW-1:0]             out_tid,
   output logic [CW-1:0]               out_cnt,
   output logic [W-1:0]                slot_vld,
   output logic [W-1:0][AW-1:0]        slot_pc,
   output logic [W-1:0][UW-1:0]        slot_upc,
   output logic [W-1:0][31:0]          slot_insn,
   output logic [W-1:0][AW-1:0]        slot_tgt_pc,
   output logic [W-1:0][AW-1:0]        slot_tgt_npc,
   output logic [W-1:0][SEQW-1:0]      slot_seq,
   output logic                        out_fault,
   output logic [1:0]                  out_state,
   output logic                        wb_we,
   output logic [TIDW-1:0]             wb_tid,
   output logic [AW-1:0]               wb_pc,
   output logic [AW-1:0]               wb_npc,
   output logic [UW-1:0]               wb_upc
);
   import fga_pkg::*;

   localparam int LB   = $clog2(LINE_BYTES);
   localparam int OFFW = LB + 1;
   localparam logic [AW-1:0] ISZ = AW'(FGA_ISZ);

   generate
      if (W < 1) begin : g_bad_w
         $error("fetch_group_asm: W must be at least 1");
      end
      if (LINE_BYTES < 8 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("fetch_group_asm: LINE_BYTES must be a power of two, 8 or more");
      end
      if (AW <= LB) begin : g_bad_aw
         $error("fetch_group_asm: AW must exceed the line offset width");
      end
      if (UW < 1) begin : g_bad_uw
         $error("fetch_group_asm: UW must be at least 1");
      end
   endgenerate

   // walk chain state between slot stages
   logic [W:0]                c_act, c_mid, c_brk;
   logic [W:0][OFFW-1:0]      c_off;
   logic [W:0][AW-1:0]        c_pc, c_npc;
   logic [W:0][UW-1:0]        c_upc;

   logic [W-1:0]              g_emit, g_qui;
   logic [W-1:0][31:0]        g_insn;
   logic [W-1:0][AW-1:0]      g_tpc, g_tnpc;

   always_comb begin
      c_act[0] = 1'b1;
      c_mid[0] = 1'b0;
      c_brk[0] = 1'b0;
      c_off[0] = {1'b0, pc[LB-1:2], 2'b00};
      c_pc[0]  = pc;
      c_npc[0] = npc;
      c_upc[0] = upc;
   end

   generate
      for (genvar k = 0; k < W; k++) begin : g_slot
         fga_slot_stage #(
            .AW(AW), .UW(UW), .LINE_BYTES(LINE_BYTES), .DELAY_SLOT(DELAY_SLOT)
         ) stage_i (
            .i_act     (c_act[k]),
            .i_off     (c_off[k]),
            .i_pc      (c_pc[k]),
            .i_npc     (c_npc[k]),
            .i_upc     (c_upc[k]),
            .i_mid     (c_mid[k]),
            .i_brk     (c_brk[k]),
            .line_data (line_data),
            .w_uops    (w_uops),
            .w_ctrl    (w_ctrl),
            .w_taken   (w_taken),
            .w_target  (w_target),
            .w_quiesce (w_quiesce),
            .s_emit    (g_emit[k]),
            .s_insn    (g_insn[k]),
            .s_tgt_pc  (g_tpc[k]),
            .s_tgt_npc (g_tnpc[k]),
            .s_qui     (g_qui[k]),
            .o_act     (c_act[k+1]),
            .o_off     (c_off[k+1]),
            .o_pc      (c_pc[k+1]),
            .o_npc     (c_npc[k+1]),
            .o_upc     (c_upc[k+1]),
            .o_mid     (c_mid[k+1]),
            .o_brk     (c_brk[k+1])
         );
      end
   endgenerate

   // group selection: normal walk or single fault-carrying slot
   logic [CW-1:0]          n_cnt;
   logic [W-1:0]           n_vld;
   logic [W-1:0][AW-1:0]   n_pcs, n_tpc, n_tnpc;
   logic [W-1:0][UW-1:0]   n_upcs;
   logic [W-1:0][31:0]     n_insn;
   logic [1:0]             n_state;
   logic                   any_qui;

   always_comb begin
      any_qui = |g_qui;
      n_vld   = g_emit;
      n_cnt   = '0;
      for (int k = 0; k < W; k++) begin
         n_cnt     = n_cnt + CW'(g_emit[k]);
         n_pcs[k]  = c_pc[k];
         n_upcs[k] = c_upc[k];
         n_insn[k] = g_insn[k];
         n_tpc[k]  = g_tpc[k];
         n_tnpc[k] = g_tnpc[k];
      end
      n_state = any_qui ? FGA_QUIESCE : FGA_RUN;
      if (fault) begin
         n_vld     = W'(1);
         n_cnt     = CW'(1);
         n_insn[0] = NOP_INSN;
         n_tpc[0]  = npc;
         n_tnpc[0] = npc + ISZ;
         n_state   = FGA_TRAP;
      end
   end

   logic [SEQW-1:0] seq_ctr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld      <= 1'b0;
         out_tid      <= '0;
         out_cnt      <= '0;
         slot_vld     <= '0;
         slot_pc      <= '0;
         slot_upc     <= '0;
         slot_insn    <= '0;
         slot_tgt_pc  <= '0;
         slot_tgt_npc <= '0;
         slot_seq     <= '0;
         out_fault    <= 1'b0;
         out_state    <= FGA_RUN;
         wb_we        <= 1'b0;
         wb_tid       <= '0;
         wb_pc        <= '0;
         wb_npc       <= '0;
         wb_upc       <= '0;
         seq_ctr      <= '0;
      end else begin
         out_vld <= go;
         wb_we   <= go && !fault;
         if (go) begin
            out_tid      <= tid;
            out_cnt      <= n_cnt;
            slot_vld     <= n_vld;
            slot_pc      <= n_pcs;
            slot_upc     <= n_upcs;
            slot_insn    <= n_insn;
            slot_tgt_pc  <= n_tpc;
            slot_tgt_npc <= n_tnpc;
            for (int k = 0; k < W; k++) begin
               slot_seq[k] <= seq_ctr + SEQW'(k);
            end
            out_fault    <= fault;
            out_state    <= n_state;
            wb_tid       <= tid;
            wb_pc        <= c_pc[W];
            wb_npc       <= c_npc[W];
            wb_upc       <= c_upc[W];
            seq_ctr      <= seq_ctr + SEQW'(n_cnt);
         end else begin
            slot_vld     <= '0;
         end
      end
   end
endmodule

// File: rtl/fga_chk.sv
module fga_chk #(
   parameter int W    = 4,
   parameter int SEQW = 16,
   localparam int CW  = $clog2(W + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            go,
   input logic            out_vld,
   input logic [CW-1:0]   out_cnt,
   input logic [W-1:0]    slot_vld,
   input logic [SEQW-1:0] seq0,
   input logic            out_fault,
   input logic [1:0]      out_state,
   input logic            wb_we
);
   logic            have_prev;
   logic [SEQW-1:0] nxt_seq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         nxt_seq   <= '0;
      end else if (out_vld) begin
         have_prev <= 1'b1;
         nxt_seq   <= seq0 + SEQW'(out_cnt);
      end
   end

   p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(go) |-> !out_vld);
   p_idle_slots_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> (slot_vld == '0 && !wb_we));
   p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_cnt != '0 && out_cnt <= CW'(W)));
   p_cnt_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ($countones(slot_vld) == int'(out_cnt)));
   p_fault_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_fault) |-> (out_cnt == CW'(1) && !wb_we && out_state == 2'd2));
   p_quiesce_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_state == 2'd1) |-> wb_we);
   p_seq_chain_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && have_prev) |-> seq0 == nxt_seq);
   p_first_seq_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !have_prev) |-> seq0 == '0);
endmodule

bind fetch_group_asm fga_chk #(.W(W), .SEQW(SEQW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .go        (go),
   .out_vld   (out_vld),
   .out_cnt   (out_cnt),
   .slot_vld  (slot_vld),
   .seq0      (slot_seq[0]),
   .out_fault (out_fault),
   .out_state (out_state),
   .wb_we     (wb_we)
);

// File: tb/fetch_group_asm_tb_top.sv
module fetch_group_asm_tb_top;
   localparam int W = 4, AW = 32, UW = 4, LINE = 32, TIDW = 2, SEQW = 16;
   localparam int WORDS = LINE / 4;
   localparam int CW = $clog2(W + 1);
   localparam logic [31:0] NOP = 32'hFFFF_0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic                     go = 1'b0, fault = 1'b0;
   logic [TIDW-1:0]          tid = '0;
   logic [AW-1:0]            pc = '0, npc = '0;
   logic [UW-1:0]            upc = '0;
   logic [WORDS-1:0][31:0]   line_data;
   logic [WORDS-1:0][UW-1:0] w_uops;
   logic [WORDS-1:0]         w_ctrl, w_taken, w_quiesce;
   logic [WORDS-1:0][AW-1:0] w_target;

   logic                     out_vld, out_fault, wb_we;
   logic [TIDW-1:0]          out_tid, wb_tid;
   logic [CW-1:0]            out_cnt;
   logic [W-1:0]             slot_vld;
   logic [W-1:0][AW-1:0]     slot_pc, slot_tgt_pc, slot_tgt_npc;
   logic [W-1:0][UW-1:0]     slot_upc;
   logic [W-1:0][31:0]       slot_insn;
   logic [W-1:0][SEQW-1:0]   slot_seq;
   logic [1:0]               out_state;
   logic [AW-1:0]            wb_pc, wb_npc;
   logic [UW-1:0]            wb_upc;

   fetch_group_asm #(.W(W), .AW(AW), .UW(UW), .LINE_BYTES(LINE), .TIDW(TIDW),
                     .SEQW(SEQW), .NOP_INSN(NOP)) dut_i (
      .clk(clk), .rst_n(rst_n), .go(go), .tid(tid), .pc(pc), .npc(npc), .upc(upc),
      .fault(fault), .line_data(line_data), .w_uops(w_uops), .w_ctrl(w_ctrl),
      .w_taken(w_taken), .w_target(w_target), .w_quiesce(w_quiesce),
      .out_vld(out_vld), .out_tid(out_tid), .out_cnt(out_cnt), .slot_vld(slot_vld),
      .slot_pc(slot_pc), .slot_upc(slot_upc), .slot_insn(slot_insn),
      .slot_tgt_pc(slot_tgt_pc), .slot_tgt_npc(slot_tgt_npc), .slot_seq(slot_seq),
      .out_fault(out_fault), .out_state(out_state), .wb_we(wb_we), .wb_tid(wb_tid),
      .wb_pc(wb_pc), .wb_npc(wb_npc), .wb_upc(wb_upc));

   typedef struct {
      string          tag;
      int             cnt;
      logic [AW-1:0]  pcs [W];
      logic [UW-1:0]  upcs [W];
      logic [31:0]    insn [W];
      logic [AW-1:0]  tpc [W];
      logic [AW-1:0]  tnpc [W];
      logic           flt;
      int             state;
      logic           we;
      logic [AW-1:0]  wpc, wnpc;
      logic [UW-1:0]  wupc;
      int             seq0;
      logic [TIDW-1:0] t;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0, n_bad = 0, seq_model = 0;
   bit   done = 1'b0;

   task automatic check(string tag, string what, longint act, longint expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   task automatic clear_attrs();
      for (int i = 0; i < WORDS; i++) begin
         line_data[i] = 32'hC0DE_0000 + 32'(i);
         w_uops[i]    = UW'(1);
         w_target[i]  = '0;
      end
      w_ctrl = '0; w_taken = '0; w_quiesce = '0;
   endtask

   // requirement model of one group
   function automatic exp_t model(string tag, logic [AW-1:0] p, logic [AW-1:0] np,
                                  logic [UW-1:0] up, logic f);
      exp_t e;
      int off, w, c;
      bit stop, inner, brk, tk;
      e.tag = tag; e.seq0 = seq_model; e.flt = f; e.state = 0; e.t = tid;
      for (int k = 0; k < W; k++) begin
         e.pcs[k] = '0; e.upcs[k] = '0; e.insn[k] = '0; e.tpc[k] = '0; e.tnpc[k] = '0;
      end
      if (f) begin
         e.cnt = 1; e.pcs[0] = p; e.upcs[0] = up; e.insn[0] = NOP;
         e.tpc[0] = np; e.tnpc[0] = np + 4; e.state = 2; e.we = 0;
         e.wpc = '0; e.wnpc = '0; e.wupc = '0;
         return e;
      end
      off = int'(p % LINE) & ~3; c = 0; stop = 0;
      while (!stop && off < LINE && c < W) begin
         w = off / 4; brk = (p + 4 != np); inner = 1;
         while (inner && c < W) begin
            e.pcs[c] = p; e.upcs[c] = up; e.insn[c] = line_data[w]; tk = 0;
            if (w_ctrl[w]) begin
               tk = w_taken[w];
               p = tk ? w_target[w] : p + 4; np = p + 4; up = 0; inner = 0;
            end else if (w_uops[w] > 1 && up != w_uops[w] - 1) begin
               up = up + 1;
            end else begin
               p = np; np = np + 4; up = 0; inner = 0;
            end
            e.tpc[c] = p; e.tnpc[c] = np; c++;
            if (w_quiesce[w]) begin e.state = 1; stop = 1; inner = 0; end
            if (!inner && (brk || tk)) stop = 1;
         end
         off += 4;
      end
      e.cnt = c; e.we = 1; e.wpc = p; e.wnpc = np; e.wupc = up;
      return e;
   endfunction

   task automatic drive(string tag, logic [AW-1:0] p, logic [AW-1:0] np,
                        logic [UW-1:0] up, logic f, logic [TIDW-1:0] t);
      exp_t e;
      @(negedge clk);
      pc = p; npc = np; upc = up; fault = f; tid = t;
      e = model(tag, p, np, up, f);
      seq_model += e.cnt;
      exp_q.push_back(e);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         if (exp_q.size() == 0) begin
            check("R12", "unexpected group", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, "cnt R3", out_cnt, e.cnt);
            check(e.tag, "slot_vld R3", slot_vld, (1 << e.cnt) - 1);
            check(e.tag, "state R8", out_state, e.state);
            check(e.tag, "fault R9", out_fault, e.flt);
            check(e.tag, "wb_we R10", wb_we, e.we);
            check(e.tag, "tid", out_tid, e.t);
            check(e.tag, "seq0 R11", slot_seq[0], e.seq0);
            if (e.we) begin
               check(e.tag, "wb_pc R10", wb_pc, e.wpc);
               check(e.tag, "wb_npc R10", wb_npc, e.wnpc);
               check(e.tag, "wb_upc R10", wb_upc, e.wupc);
            end
            for (int k = 0; k < W; k++) begin
               if (k < e.cnt) begin
                  check(e.tag, $sformatf("pc[%0d] R1", k), slot_pc[k], e.pcs[k]);
                  check(e.tag, $sformatf("upc[%0d] R5", k), slot_upc[k], e.upcs[k]);
                  check(e.tag, $sformatf("insn[%0d] R1", k), slot_insn[k], e.insn[k]);
                  check(e.tag, $sformatf("tpc[%0d] R4", k), slot_tgt_pc[k], e.tpc[k]);
                  check(e.tag, $sformatf("tnpc[%0d] R4", k), slot_tgt_npc[k], e.tnpc[k]);
                  check(e.tag, $sformatf("seq[%0d] R11", k), slot_seq[k], e.seq0 + k);
               end
            end
         end
      end
   end

   initial begin
      clear_attrs();
      repeat (3) @(negedge clk);
      // R13 reset state
      check("R13", "out_vld", out_vld, 0);
      check("R13", "slot_vld", slot_vld, 0);
      check("R13", "wb_we", wb_we, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      clear_attrs();
      drive("R1 R3 R4 full width", 32'h1000, 32'h1004, 0, 0, 0);
      drive("R1 R2 line end mid", 32'h1014, 32'h1018, 0, 0, 1);
      drive("R2 last two words", 32'h1018, 32'h101C, 0, 0, 2);

      clear_attrs();
      w_ctrl[2] = 1; w_taken[2] = 1; w_target[2] = 32'h2000;
      drive("R7 taken branch", 32'h1004, 32'h1008, 0, 0, 0);

      clear_attrs();
      w_ctrl[1] = 1; w_taken[1] = 0; w_target[1] = 32'h3000;
      drive("R7 not taken", 32'h1000, 32'h1004, 0, 0, 3);

      clear_attrs();
      drive("R6 pending redirect", 32'h1000, 32'h1100, 0, 0, 0);

      clear_attrs();
      w_uops[0] = 3;
      drive("R5 macro then word", 32'h1000, 32'h1004, 0, 0, 1);

      clear_attrs();
      w_uops[0] = 6;
      drive("R5 R3 macro cut by width", 32'h1000, 32'h1004, 0, 0, 1);

      clear_attrs();
      w_quiesce[1] = 1;
      drive("R8 quiesce", 32'h1000, 32'h1004, 0, 0, 2);

      clear_attrs();
      drive("R9 fault slot", 32'h1008, 32'h100C, 0, 1, 3);

      clear_attrs();
      w_uops[6] = 2; w_ctrl[7] = 1; w_taken[7] = 1; w_target[7] = 32'h4000;
      drive("R5 R7 R11 mixed", 32'h1018, 32'h101C, 0, 0, 0);

      // R12 idle: monitor flags any group without a pending expectation
      repeat (5) @(negedge clk);
      check("R12", "idle out_vld", out_vld, 0);
      check("R12", "idle slot_vld", slot_vld, 0);
      check("R12", "queue drained", exp_q.size(), 0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule